// File: doc/BRIEF.md
# Serial Interrupt Bus Slave

This block is the peripheral end of a single-wire serial interrupt bus. The bus line is pulled high and can be driven low by any agent. A host opens each bus cycle with a long low pulse. After that pulse the slave counts clocks to find the one data frame it owns. If its local interrupt is active, it pulls the line low on that frame's sample clock. It then drives the line high for one clock to restore it, and after that it releases the line.

When all 32 frames are over, the host closes the cycle with a short low pulse. The slave measures the width of that pulse to learn the mode of the next cycle. A width of two clocks means quiet mode. A width of three clocks means continuous mode. Any other width is a protocol error, and the slave falls back to continuous mode. The mode is presented on `quiet_mode`. The frame number is taken from `slot_sel` while reset is held, and it stays fixed until the next reset.

The controller has five states:
- `ST_IDLE`: the line is high. A low sample moves it to `ST_START`.
- `ST_START`: it counts the low run. On the first high sample it moves to `ST_FRAMES` if the run was at least 4 clocks long; otherwise it goes back to `ST_IDLE`.
- `ST_FRAMES`: it steps the period counter. At the end of period 97 it moves to `ST_WAIT_STOP`.
- `ST_WAIT_STOP`: a low sample moves it to `ST_STOP`.
- `ST_STOP`: on the first high sample it updates the mode and returns to `ST_IDLE`.

Top module: `sirq_slave`

## Requirements
- R1: While reset is held and right after it, `sio_oe_n` is 1 (line released) and `quiet_mode` is 0 (continuous).
- R2: A start is only recognised for a low run of at least 4 clocks seen while idle. A shorter low run causes no drive at any later clock until a valid start arrives.
- R3: Number the clocks after a start from 1, where clock 1 is the first high clock after the start pulse. For a latched frame number n in 1..21 with `irq_in` high, the slave drives low (`sio_oe_n`=0, `sio_dout`=0) during clock 3n-1 and on no other clock.
- R4: `irq_in` is sampled at the clock edge that begins the sample clock. If it is low, the slave does not drive during that cycle.
- R5: Right after its low clock, the slave drives high for exactly one clock (`sio_oe_n`=0, `sio_dout`=1) and then releases the line.
- R6: A latched frame number of 0 or 22..31 never causes a drive.
- R7: A stop pulse 2 clocks wide sets `quiet_mode` to 1. The update happens at the edge that samples the first high clock after the stop pulse.
- R8: A stop pulse 3 clocks wide sets `quiet_mode` to 0, with the same timing as R7.
- R9: A low run of any other width after the frames (1 clock, or 4 or more) clears `quiet_mode` to 0, and the slave accepts the next start normally.
- R10: The slave never drives during the start pulse, the stop pulse, or while idle.
- R11: `slot_sel` is captured while reset is held. Changes to it after reset have no effect on which clock is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low; `slot_sel` is captured while it is low |
| slot_sel | input | 5 | Assigned frame number |
| irq_in | input | 1 | Local interrupt request, active high |
| sio_in | input | 1 | Sampled level of the bus line |
| sio_oe_n | output | 1 | Line output enable, active low |
| sio_dout | output | 1 | Value driven onto the line while enabled |
| quiet_mode | output | 1 | Mode of the next cycle: 1 quiet, 0 continuous |

## Verification
The assertions check several properties on every clock:
- a low drive is always followed by exactly one high drive and then a release;
- there is no drive outside the frame phase;
- a latched unassigned frame number never drives;
- there is no low drive unless the interrupt was high one edge earlier;
- the mode changes only when leaving the stop state.

Some behaviour only the bench scenarios can show:
- the exact clock position 3n-1 for every frame number;
- short start pulses being ignored;
- the mode chosen from each stop width, including the error widths;
- the frame number being held across later changes to `slot_sel`.

// File: rtl/sirq_slave_pkg.sv
package sirq_slave_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_FRAMES,
        ST_WAIT_STOP,
        ST_STOP
    } sirq_state_e;
endpackage

// File: rtl/sirq_low_meter.sv
// Length of the current run of low samples on the bus line, saturating.
module sirq_low_meter #(
    parameter int LOW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic [LOW_W-1:0] low_run
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (line_in) begin
            low_run <= '0;
        end else if (low_run != {LOW_W{1'b1}}) begin
            low_run <= low_run + 1'b1;
        end
    end
endmodule

// File: rtl/sirq_slot_map.sv
// Maps a frame number to its sample-clock index and flags assigned frames.
module sirq_slot_map #(
    parameter int SEL_W       = 5,
    parameter int CNT_W       = 7,
    parameter int USED_FRAMES = 21,
    parameter int FRAME_CLKS  = 3
) (
    input  logic [SEL_W-1:0] slot,
    output logic [CNT_W-1:0] samp_idx,
    output logic             slot_ok
);
    always_comb begin
        slot_ok  = (slot != '0) && (int'(slot) <= USED_FRAMES);
        samp_idx = CNT_W'(FRAME_CLKS * int'(slot) - 1);
    end
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
    import sirq_slave_pkg::*;
#(
    parameter int SEL_W       = 5,
    parameter int NUM_FRAMES  = 32,
    parameter int USED_FRAMES = 21,
    parameter int FRAME_CLKS  = 3,
    parameter int START_MIN   = 4,
    parameter int STOP_QUIET  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic             irq_in,
    input  logic             sio_in,
    output logic             sio_oe_n,
    output logic             sio_dout,
    output logic             quiet_mode
);
    localparam int LAST_CNT = FRAME_CLKS * NUM_FRAMES + 1;
    localparam int CNT_W    = $clog2(LAST_CNT + 1);
    localparam int LOW_W    = $clog2(START_MIN + 1) + 1;

    sirq_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] slot_q;
    logic             irq_q;
    logic             drove_q;
    logic             quiet_q, quiet_d;
    logic [LOW_W-1:0] low_run;
    logic [CNT_W-1:0] samp_idx;
    logic             slot_ok;
    logic             drive_lo;
    logic             drive_hi;

    sirq_low_meter #(.LOW_W(LOW_W)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (sio_in),
        .low_run (low_run)
    );

    sirq_slot_map #(
        .SEL_W       (SEL_W),
        .CNT_W       (CNT_W),
        .USED_FRAMES (USED_FRAMES),
        .FRAME_CLKS  (FRAME_CLKS)
    ) u_map (
        .slot     (slot_q),
        .samp_idx (samp_idx),
        .slot_ok  (slot_ok)
    );

    // Next-state decisions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        quiet_d = quiet_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!sio_in) state_d = ST_START;
            end
            ST_START: begin
                if (sio_in) begin
                    if (low_run >= LOW_W'(START_MIN)) begin
                        state_d = ST_FRAMES;
                        cnt_d   = CNT_W'(2);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FRAMES: begin
                if (cnt_q == CNT_W'(LAST_CNT)) state_d = ST_WAIT_STOP;
                else                           cnt_d   = cnt_q + 1'b1;
            end
            ST_WAIT_STOP: begin
                if (!sio_in) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (sio_in) begin
                    state_d = ST_IDLE;
                    quiet_d = (low_run == LOW_W'(STOP_QUIET));
                end
            end
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            slot_q  <= slot_sel;
            irq_q   <= 1'b0;
            drove_q <= 1'b0;
            quiet_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= irq_in;
            drove_q <= drive_lo;
            quiet_q <= quiet_d;
        end
    end

    // Outputs
    always_comb begin
        drive_lo   = (state_q == ST_FRAMES) && (cnt_q == samp_idx) && slot_ok && irq_q;
        drive_hi   = (state_q == ST_FRAMES) && drove_q;
        sio_oe_n   = !(drive_lo || drive_hi);
        sio_dout   = drive_hi;
        quiet_mode = quiet_q;
    end
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk
    import sirq_slave_pkg::*;
#(
    parameter int SEL_W       = 5,
    parameter int USED_FRAMES = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_in,
    input logic             sio_oe_n,
    input logic             sio_dout,
    input logic             quiet_mode,
    input sirq_state_e      state_q,
    input logic [SEL_W-1:0] slot_q
);
    AST_RECOVERY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sio_oe_n && !sio_dout) |=> (!sio_oe_n && sio_dout)); // R5
    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sio_oe_n && sio_dout) |=> sio_oe_n); // R5
    AST_SILENT_OUTSIDE_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FRAMES) |-> sio_oe_n); // R10
    AST_UNASSIGNED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == '0) || (slot_q > SEL_W'(USED_FRAMES))) |-> sio_oe_n); // R6
    AST_LOW_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sio_oe_n && !sio_dout) |-> $past(irq_in)); // R4
    AST_MODE_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STOP) |=> $stable(quiet_mode)); // R7
endmodule

bind sirq_slave sirq_slave_chk #(
    .SEL_W       (SEL_W),
    .USED_FRAMES (USED_FRAMES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .sio_oe_n   (sio_oe_n),
    .sio_dout   (sio_dout),
    .quiet_mode (quiet_mode),
    .state_q    (state_q),
    .slot_q     (slot_q)
);

// File: tb/sirq_slave_bench.sv
`timescale 1ns/1ps
module sirq_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] slot_sel = '0;
    logic       irq_in = 1'b0;
    logic       host_low = 1'b0;
    logic       sio_in;
    logic       sio_oe_n, sio_dout, quiet_mode;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign sio_in = host_low ? 1'b0 : (!sio_oe_n ? sio_dout : 1'b1);

    sirq_slave u_sirq_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_sel   (slot_sel),
        .irq_in     (irq_in),
        .sio_in     (sio_in),
        .sio_oe_n   (sio_oe_n),
        .sio_dout   (sio_dout),
        .quiet_mode (quiet_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int sel);
        rst_n    = 1'b0;
        slot_sel = 5'(sel);
        repeat (3) @(negedge clk);
        check("R1 oe_n in reset", int'(sio_oe_n), 1);
        check("R1 quiet in reset", int'(quiet_mode), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 oe_n after reset", int'(sio_oe_n), 1);
        check("R1 quiet after reset", int'(quiet_mode), 0);
    endtask

    // One full bus cycle; sel is the frame number the slave was reset with
    task automatic run_cycle(input int sel, input bit irq, input int start_len, input int stop_len);
        bit valid = (sel >= 1) && (sel <= 21);
        irq_in = irq;
        repeat (start_len) begin
            @(negedge clk);
            host_low = 1'b1;
            check("R10 no drive in start", int'(sio_oe_n), 1);
        end
        @(negedge clk);
        host_low = 1'b0;
        for (int k = 1; k <= 97; k++) begin
            bit exp_lo, exp_hi;
            if (k > 1) @(negedge clk);
            exp_lo = valid && irq && (k == 3 * sel - 1);
            exp_hi = valid && irq && (k == 3 * sel);
            if (exp_lo) begin
                check("R3 low on sample clock oe", int'(sio_oe_n), 0);
                check("R3 low on sample clock data", int'(sio_dout), 0);
            end else if (exp_hi) begin
                check("R5 recovery high oe", int'(sio_oe_n), 0);
                check("R5 recovery high data", int'(sio_dout), 1);
            end else if (!valid) begin
                check("R6 unassigned frame silent", int'(sio_oe_n), 1);
            end else if (!irq) begin
                check("R4 no irq no drive", int'(sio_oe_n), 1);
            end else begin
                check("R3 R5 released elsewhere", int'(sio_oe_n), 1);
            end
        end
        repeat (stop_len) begin
            @(negedge clk);
            host_low = 1'b1;
            check("R10 no drive in stop", int'(sio_oe_n), 1);
        end
        @(negedge clk);
        host_low = 1'b0;
        @(negedge clk);
        if (stop_len == 2)      check("R7 quiet after 2-clock stop", int'(quiet_mode), 1);
        else if (stop_len == 3) check("R8 continuous after 3-clock stop", int'(quiet_mode), 0);
        else                    check("R9 continuous after bad stop", int'(quiet_mode), 0);
        repeat (3) begin
            @(negedge clk);
            check("R10 no drive while idle", int'(sio_oe_n), 1);
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Sweep every frame number with both interrupt levels and all stop widths
        for (int sel = 0; sel < 32; sel++) begin
            do_reset(sel);
            run_cycle(sel, 1'b1, 4, 2);
            run_cycle(sel, 1'b1, 5, 3);
            run_cycle(sel, 1'b0, 4, 2);
            run_cycle(sel, 1'b1, 6, (sel % 2 == 1) ? 1 : 5);
            run_cycle(sel, 1'b1, 4, 3);   // R9: next start accepted after error
        end

        // R2: a 3-clock low pulse in idle is not a start
        do_reset(2);
        irq_in = 1'b1;
        repeat (3) begin
            @(negedge clk);
            host_low = 1'b1;
        end
        @(negedge clk);
        host_low = 1'b0;
        repeat (110) begin
            @(negedge clk);
            check("R2 short pulse ignored", int'(sio_oe_n), 1);
        end
        run_cycle(2, 1'b1, 4, 2);

        // R11: frame number held after reset despite input change
        do_reset(4);
        slot_sel = 5'd9;
        run_cycle(4, 1'b1, 4, 3);
        slot_sel = 5'd0;
        run_cycle(4, 1'b1, 7, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule